// File: doc/BRIEF.md
# Multi-Lane Pass/Fail Window Centering Controller

This block steers a search for the passing delay window across a group of byte lanes that share one test engine. Each lane has an external delay stepper that can only move forward by one step at a time. The controller alternates between asking for one test pass, which returns a failure bit per lane, and asking the steppers of chosen lanes to advance by one step. Because the lanes cannot be tested one at a time, every lane that is still searching moves together with the others in each iteration.

The search has two phases. In the first phase, each lane steps until it reaches the first setting where its test passes. In the second phase, stepping continues from the same setting until the lane's test starts failing again. In both phases, a lane that has reached its target result keeps stepping for a fixed number of confirming iterations before it drops out. The controller keeps a lower and an upper step count for each lane. When both phases are complete, it removes the confirmation overshoot from both counts and reports the midpoint as the lane's centre step count. If any stepper reports that it cannot move further, the search stops and reports failure.

Top module: `window_centre`

## Requirements
- R1: During an evaluation, an active lane whose failure bit differs from the phase target (target is pass, bit 0, in the lower phase and fail, bit 1, in the upper phase) is included in the next step request and its count for that phase is incremented. Bit l of `test_fail_i` and of `step_req_o` belongs to lane l.
- R2: An active lane whose failure bit matches the target is still stepped and counted until it has matched CONFIRM (default 10) times in the current phase. At its next match after that, it is retired: it issues no more step requests in that phase.
- R3: A phase ends when no lane is active. The confirmation counts are cleared and all lanes become active again at each phase start. Each lane's upper count starts from its final lower count. With a passing window that spans settings lo to hi-1 and is wider than CONFIRM, each lane takes exactly hi+10 steps in total.
- R4: After a successful search, the centre of lane l, on `centre_o[8l+7:8l]`, equals (max(lower-9,0) + max(upper-9,0)) / 2 with truncation. Here 9 is CONFIRM-1. For the window in R3 this is (lo+hi+2)/2.
- R5: If `step_err_i` is high when `step_done_i` arrives, the search ends with `done_o` high and `ok_o` low. No further test is requested, and `centre_o` keeps the values it had before.
- R6: `test_req_o` is never high while a step request is outstanding. `step_req_o` holds its value until `step_done_i` arrives, and `test_req_o` holds until `test_ack_i` arrives.
- R7: After reset, `done_o`, `test_req_o` and `step_req_o` are low and every centre value is 0.
- R8: `done_o` is high for exactly one cycle at the end of each search. `ok_o` is high in that cycle only if both phases completed. The centre outputs change only in that cycle.
- R9: A pulse on `start_i` while a search is running has no effect on that search or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a search when idle |
| test_req_o | output | 1 | Requests one test pass; held until acknowledged |
| test_ack_i | input | 1 | Test pass finished; `test_fail_i` is valid |
| test_fail_i | input | NLANES | Per-lane failure bits of the finished test |
| step_req_o | output | NLANES | Lanes whose stepper should advance by one step |
| step_done_i | input | 1 | All requested steps have completed |
| step_err_i | input | 1 | A requested stepper could not advance (valid with `step_done_i`) |
| done_o | output | 1 | One-cycle end-of-search pulse |
| ok_o | output | 1 | Search succeeded (valid with `done_o`) |
| centre_o | output | NLANES*CNT_W | Per-lane centre step counts, lane l in bits [8l+7:8l] |

## Verification
The assertions check the handshake discipline on every cycle: a test is never requested while a step is outstanding, and both requests hold steady until they are answered. They also check that the end-of-search pulse lasts a single cycle and that the centre values move only in that cycle, and never when a search fails. Only the bench's scenarios can show the numeric results. These include the exact number of steps each lane takes before it retires in each phase, the overshoot-corrected midpoint for windows of different positions and widths, and the abort path when the stepper errors in the lower or the upper phase. The scenarios also show that a stray start pulse in the middle of a search is ignored.

// File: rtl/window_centre_pkg.sv
package window_centre_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TEST = 2'd1,
        ST_STEP = 2'd2
    } wc_state_e;

    // phase encoding: 0 = looking for passing writes, 1 = looking for failing writes
    localparam logic PH_LOWER = 1'b0;
    localparam logic PH_UPPER = 1'b1;

endpackage

// File: rtl/wc_lane.sv
module wc_lane #(
    parameter int CNT_W   = 8,
    parameter int CONFIRM = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             phase_adv_i,
    input  logic             phase_i,
    input  logic             eval_i,
    input  logic             fail_i,
    output logic             step_o,
    output logic             active_o,
    output logic [CNT_W-1:0] lower_o,
    output logic [CNT_W-1:0] upper_o
);
    localparam int CONF_W = $clog2(CONFIRM + 1);
    localparam logic [CONF_W-1:0] CONF_MAX = CONF_W'(CONFIRM);
    localparam logic [CNT_W-1:0]  CNT_TOP  = {CNT_W{1'b1}};

    typedef struct packed {
        logic              active;
        logic [CONF_W-1:0] conf;
        logic [CNT_W-1:0]  lower;
        logic [CNT_W-1:0]  upper;
    } lane_t;

    lane_t st_q, st_d;
    logic  match;
    logic  want;

    always_comb begin
        // a lane matches when its result equals the phase target
        match  = (fail_i == phase_i);
        want   = st_q.active && (!match || (st_q.conf < CONF_MAX));
        step_o = eval_i && want;

        st_d = st_q;
        if (clr_i) begin
            st_d.active = 1'b1;
            st_d.conf   = '0;
            st_d.lower  = '0;
            st_d.upper  = '0;
        end else if (phase_adv_i) begin
            st_d.active = 1'b1;
            st_d.conf   = '0;
            st_d.upper  = st_q.lower;
        end else if (eval_i && st_q.active) begin
            if (want) begin
                if (phase_i == window_centre_pkg::PH_UPPER) begin
                    st_d.upper = (st_q.upper == CNT_TOP) ? st_q.upper : st_q.upper + 1'b1;
                end else begin
                    st_d.lower = (st_q.lower == CNT_TOP) ? st_q.lower : st_q.lower + 1'b1;
                end
                if (match) begin
                    st_d.conf = st_q.conf + 1'b1;
                end
            end else begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign lower_o  = st_q.lower;
    assign upper_o  = st_q.upper;

endmodule

// File: rtl/wc_centre.sv
module wc_centre #(
    parameter int CNT_W   = 8,
    parameter int CONFIRM = 10
) (
    input  logic [CNT_W-1:0] lower_i,
    input  logic [CNT_W-1:0] upper_i,
    output logic [CNT_W-1:0] centre_o
);
    localparam logic [CNT_W-1:0] OVERSHOOT = CNT_W'(CONFIRM - 1);

    logic [CNT_W-1:0] lo_adj;
    logic [CNT_W-1:0] hi_adj;
    logic [CNT_W:0]   sum;

    always_comb begin
        lo_adj   = (lower_i > OVERSHOOT) ? lower_i - OVERSHOOT : '0;
        hi_adj   = (upper_i > OVERSHOOT) ? upper_i - OVERSHOOT : '0;
        sum      = {1'b0, lo_adj} + {1'b0, hi_adj};
        centre_o = sum[CNT_W:1];
    end

endmodule

// File: rtl/window_centre.sv
module window_centre #(
    parameter int NLANES  = 8,
    parameter int CNT_W   = 8,
    parameter int CONFIRM = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    output logic                    test_req_o,
    input  logic                    test_ack_i,
    input  logic [NLANES-1:0]       test_fail_i,
    output logic [NLANES-1:0]       step_req_o,
    input  logic                    step_done_i,
    input  logic                    step_err_i,
    output logic                    done_o,
    output logic                    ok_o,
    output logic [NLANES*CNT_W-1:0] centre_o
);
    import window_centre_pkg::*;

    typedef struct packed {
        wc_state_e                st;
        logic                     phase;
        logic [NLANES-1:0]        mask;
        logic                     done;
        logic                     ok;
        logic [NLANES*CNT_W-1:0]  centre;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                    clr;
    logic                    eval;
    logic                    phase_adv;
    logic [NLANES-1:0]       step_vec;
    logic [NLANES-1:0]       active_vec;
    logic [NLANES*CNT_W-1:0] centre_calc;

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [CNT_W-1:0] lower_w;
        logic [CNT_W-1:0] upper_w;

        wc_lane #(
            .CNT_W   (CNT_W),
            .CONFIRM (CONFIRM)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr_i       (clr),
            .phase_adv_i (phase_adv),
            .phase_i     (ctl_q.phase),
            .eval_i      (eval),
            .fail_i      (test_fail_i[l]),
            .step_o      (step_vec[l]),
            .active_o    (active_vec[l]),
            .lower_o     (lower_w),
            .upper_o     (upper_w)
        );

        wc_centre #(
            .CNT_W   (CNT_W),
            .CONFIRM (CONFIRM)
        ) u_centre (
            .lower_i  (lower_w),
            .upper_i  (upper_w),
            .centre_o (centre_calc[l*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        clr       = (ctl_q.st == ST_IDLE) && start_i;
        eval      = (ctl_q.st == ST_TEST) && test_ack_i;
        // all active lanes retire together with no step: the phase is over
        phase_adv = eval && (step_vec == '0) && (ctl_q.phase == PH_LOWER);

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_TEST;
                    ctl_d.phase = PH_LOWER;
                    ctl_d.mask  = '0;
                end
            end
            ST_TEST: begin
                if (test_ack_i) begin
                    if (step_vec != '0) begin
                        ctl_d.mask = step_vec;
                        ctl_d.st   = ST_STEP;
                    end else if (ctl_q.phase == PH_LOWER) begin
                        ctl_d.phase = PH_UPPER;
                    end else begin
                        ctl_d.st     = ST_IDLE;
                        ctl_d.done   = 1'b1;
                        ctl_d.ok     = 1'b1;
                        ctl_d.centre = centre_calc;
                    end
                end
            end
            ST_STEP: begin
                if (step_done_i) begin
                    ctl_d.mask = '0;
                    if (step_err_i) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.ok   = 1'b0;
                    end else begin
                        ctl_d.st = ST_TEST;
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, phase: PH_LOWER, mask: '0, done: 1'b0, ok: 1'b0, centre: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign test_req_o = (ctl_q.st == ST_TEST);
    assign step_req_o = (ctl_q.st == ST_STEP) ? ctl_q.mask : '0;
    assign done_o     = ctl_q.done;
    assign ok_o       = ctl_q.ok;
    assign centre_o   = ctl_q.centre;

endmodule

// File: rtl/window_centre_chk.sv
module window_centre_chk #(
    parameter int NLANES = 8,
    parameter int CNT_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    test_req_o,
    input logic                    test_ack_i,
    input logic [NLANES-1:0]       step_req_o,
    input logic                    step_done_i,
    input logic                    done_o,
    input logic                    ok_o,
    input logic [NLANES*CNT_W-1:0] centre_o
);

    p_no_test_during_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req_o != '0) |-> !test_req_o);

    p_step_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_req_o != '0) && !step_done_i) |=> $stable(step_req_o));

    p_test_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_req_o && !test_ack_i) |=> test_req_o);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_centre_only_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(centre_o));

    p_centre_kept_on_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> $stable(centre_o));

    p_no_test_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> !test_req_o);

endmodule

bind window_centre window_centre_chk #(
    .NLANES (NLANES),
    .CNT_W  (CNT_W)
) u_window_centre_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_req_o  (test_req_o),
    .test_ack_i  (test_ack_i),
    .step_req_o  (step_req_o),
    .step_done_i (step_done_i),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .centre_o    (centre_o)
);

// File: tb/window_centre_bench.sv
`timescale 1ns/1ps
module window_centre_bench;
    localparam int NL = 8;
    localparam int CW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            test_req_o;
    logic            test_ack_i = 1'b0;
    logic [NL-1:0]   test_fail_i = '0;
    logic [NL-1:0]   step_req_o;
    logic            step_done_i = 1'b0;
    logic            step_err_i = 1'b0;
    logic            done_o;
    logic            ok_o;
    logic [NL*CW-1:0] centre_o;

    always #10 clk = ~clk;

    window_centre u_window_centre (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .test_req_o(test_req_o), .test_ack_i(test_ack_i), .test_fail_i(test_fail_i),
        .step_req_o(step_req_o), .step_done_i(step_done_i), .step_err_i(step_err_i),
        .done_o(done_o), .ok_o(ok_o), .centre_o(centre_o)
    );

    int lo [NL];
    int hi [NL];
    int lim[NL];
    int pos[NL];
    int n_checks = 0;
    int n_fail = 0;
    int order_viol = 0;
    logic [NL*CW-1:0] last_good = '0;

    typedef struct {
        bit               ok;
        logic [NL*CW-1:0] c;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // test responder: a lane fails outside its passing window [lo, hi)
    initial begin
        forever begin
            @(negedge clk);
            if (test_req_o) begin
                repeat (2) @(negedge clk);
                for (int l = 0; l < NL; l++)
                    test_fail_i[l] = !((pos[l] >= lo[l]) && (pos[l] < hi[l]));
                test_ack_i = 1'b1;
                @(negedge clk);
                test_ack_i = 1'b0;
            end
        end
    end

    // stepper responder: errors when a lane would pass its limit
    initial begin
        forever begin
            @(negedge clk);
            if (step_req_o != '0) begin
                automatic logic [NL-1:0] m = step_req_o;
                automatic bit err = 1'b0;
                repeat (1) @(negedge clk);
                for (int l = 0; l < NL; l++)
                    if (m[l] && (pos[l] + 1 > lim[l])) err = 1'b1;
                if (!err)
                    for (int l = 0; l < NL; l++)
                        if (m[l]) pos[l] = pos[l] + 1;
                step_err_i  = err;
                step_done_i = 1'b1;
                @(negedge clk);
                step_done_i = 1'b0;
                step_err_i  = 1'b0;
            end
        end
    end

    // ordering observer (R6)
    always @(negedge clk)
        if (rst_n && test_req_o && (step_req_o != '0)) order_viol++;

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                automatic exp_t e = exp_q.pop_front();
                check(ok_o == e.ok, "R8", "ok_o", ok_o, e.ok);
                for (int l = 0; l < NL; l++)
                    check(centre_o[l*CW +: CW] == e.c[l*CW +: CW],
                          e.ok ? "R4" : "R5", $sformatf("centre lane %0d", l),
                          centre_o[l*CW +: CW], e.c[l*CW +: CW]);
            end
            @(negedge clk);
            check(!done_o, "R8", "done pulse width", done_o, 0);
        end
    end

    task automatic run_case(input bit exp_ok, input bit restart_mid);
        automatic exp_t e;
        for (int l = 0; l < NL; l++) pos[l] = 0;
        e.ok = exp_ok;
        if (exp_ok) begin
            for (int l = 0; l < NL; l++) e.c[l*CW +: CW] = CW'((lo[l] + hi[l] + 2) / 2);
            last_good = e.c;
        end else begin
            e.c = last_good;
        end
        exp_q.push_back(e);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (restart_mid) begin
            repeat (25) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        repeat (3) @(negedge clk);
        if (exp_ok) begin
            for (int l = 0; l < NL; l++)
                check(pos[l] == hi[l] + 10, "R3", $sformatf("total steps lane %0d (R1 R2)", l),
                      pos[l], hi[l] + 10);
        end else begin
            check(!test_req_o, "R5", "no test after abort", test_req_o, 0);
        end
        check(exp_q.size() == 0, "R9", "results pending", exp_q.size(), 0);
    endtask

    initial begin
        for (int l = 0; l < NL; l++) begin lo[l] = 0; hi[l] = 20; lim[l] = 250; pos[l] = 0; end
        repeat (3) @(negedge clk);
        // R7 reset state
        check(!done_o, "R7", "done_o", done_o, 0);
        check(!test_req_o, "R7", "test_req_o", test_req_o, 0);
        check(step_req_o == '0, "R7", "step_req_o", step_req_o, 0);
        check(centre_o == '0, "R7", "centre_o", centre_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // varied windows
        lo = '{3, 5, 0, 7, 12, 1, 20, 9};
        hi = '{18, 25, 30, 18, 37, 41, 34, 27};
        run_case(1'b1, 1'b0);

        // all lanes pass from the first setting
        for (int l = 0; l < NL; l++) begin lo[l] = 0; hi[l] = 11 + 2 * l; end
        run_case(1'b1, 1'b0);

        // stepper error in upper phase on lane 3
        lo = '{2, 4, 6, 8, 1, 3, 5, 7};
        hi = '{20, 22, 24, 26, 21, 23, 25, 27};
        lim[3] = hi[3] + 5;
        run_case(1'b0, 1'b0);
        lim[3] = 250;

        // stepper error in lower phase on lane 0
        lo[0] = 5; lim[0] = 2;
        run_case(1'b0, 1'b0);
        lim[0] = 250;

        // good run with a stray start pulse in the middle (R9)
        lo = '{4, 0, 13, 2, 6, 9, 1, 15};
        hi = '{16, 14, 40, 30, 19, 33, 12, 29};
        run_case(1'b1, 1'b1);

        check(order_viol == 0, "R6", "test during step", order_viol, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule